// File: doc/BRIEF.md
# Dual Interval Timer with Cascade

The block holds two programmable down-counters that share a single control word. Each counter has an 8-bit reload value, a tick source, a run or hold-and-load mode, and an interrupt-clear field, and one write sets all four for both counters at once. A running counter counts down once per selected tick. It returns to its reload value every reload-value ticks and sets a sticky pending flag at that point. Counter 1 can take counter 0's reload events as its tick, which gives a 16-bit chained period.

Both live counts are read in one word, so software can interpolate between interrupts. A small mask register chooses which pending flags reach the single interrupt line. The prescaled tick enables come from outside and are one cycle wide. With a 19.2 kHz tick and a reload value of 192, a counter wraps at 100 Hz.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset both counts read 0, both pending flags are 0, the interrupt output is 0 and both counters are in hold mode.
- R2: The slice of `ctrl_wdata` for counter n begins at bit 12*n. Within the slice, bits [7:0] are the reload value, [9:8] the tick source, bit 10 the mode (1 = run, 0 = hold-and-load) and bit 11 the clear field (1 = clear pending, 0 = no-op).
- R3: In hold mode a counter shows its reload value from the cycle after the write, and it keeps that value whatever ticks arrive. When no tick arrives and no control write occurs, neither count changes.
- R4: A running counter decrements by one on each selected tick. On a tick while it reads 1, it reloads the reload value and sets its pending flag, so the wrap period is the reload value in ticks (192 ticks for a reload value of 192). A write that switches a held counter to run loads the new reload value.
- R5: A reload value of 0 acts as 256: the count reads 0, then 255 down to 1, then 0 again with the pending flag set.
- R6: Source code 0 selects `tick_slow` and code 1 selects `tick_fast`. Code 3 selects no tick. Code 2 selects no tick on counter 0.
- R7: With source code 2, counter 1 decrements once for each reload event of counter 0.
- R8: A control write with the clear field at 1 clears that counter's pending flag, and the no-op code leaves the flag unchanged. A reload event in the same cycle as a clear leaves the flag set.
- R9: A pending flag stays set until it is cleared through the control word.
- R10: `irq` is 1 exactly when some pending flag is set whose bit is set in the mask register (bit n masks counter n). `mask_we` loads that register.
- R11: `count_pair` carries counter 1 in bits [15:8] and counter 0 in bits [7:0], both taken from the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_slow | input | 1 | One-cycle enable from the low-rate prescaler |
| tick_fast | input | 1 | One-cycle enable from the high-rate prescaler |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 24 | Control word, one 12-bit slice per counter |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 2 | New mask, one bit per counter |
| count_pair | output | 16 | Live counts, counter 1 high byte, counter 0 low byte |
| pend | output | 2 | Sticky pending flags, one per counter |
| irq | output | 1 | Masked OR of the pending flags |

## Verification
Counter 0 is run from the slow tick while fast pulses are applied, so the check shows that the source select gates the count and that the enables are not simply ORed. Reload values 5, 192 and 0 are each counted through a full wrap: they separate an off-by-one period from a correct one, check the 100 Hz setting, and check that zero is treated as 256. Cascade mode is run with small reload values, so the 16-bit read shows both counters stepping in the right relation. One clear is issued in the same cycle as a wrap to show which of the two wins.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // tick source codes held per counter
  typedef enum logic [1:0] {
    SRC_SLOW  = 2'd0,
    SRC_FAST  = 2'd1,
    SRC_CHAIN = 2'd2,
    SRC_OFF   = 2'd3
  } tsrc_e;

  // control bits that follow the reload value in each slice: source(2), run(1), clear(1)
  localparam int CTL_EXTRA = 4;
endpackage

// File: rtl/tick_mux.sv
module tick_mux
  import timer_pkg::*;
#(
  parameter bit HAS_CHAIN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] sel_in,
  input  logic       tick_slow,
  input  logic       tick_fast,
  input  logic       chain_in,
  output logic       tick
);
  tsrc_e sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  sel_q <= SRC_OFF;
    else if (we) sel_q <= tsrc_e'(sel_in);
  end

  always_comb begin
    case (sel_q)
      SRC_SLOW:  tick = tick_slow;
      SRC_FAST:  tick = tick_fast;
      SRC_CHAIN: tick = HAS_CHAIN ? chain_in : 1'b0;
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/down_counter.sv
module down_counter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_run,
  input  logic             cfg_ack,
  input  logic             tick,
  output logic [DIV_W-1:0] count,
  output logic             wrap,
  output logic             pending
);
  localparam logic [DIV_W-1:0] LAST = DIV_W'(1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] count_q;
  logic             run_q;
  logic             pend_q;

  // a reload event happens on the tick that finds the count at 1
  assign wrap = run_q && tick && (count_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      run_q   <= 1'b0;
      count_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (cfg_we) begin
        div_q <= cfg_div;
        run_q <= cfg_run;
      end
      // holding, or starting from hold: take the new reload value
      if (cfg_we && (!cfg_run || !run_q))
        count_q <= cfg_div;
      else if (!run_q)
        count_q <= div_q;
      else if (tick)
        count_q <= (count_q == LAST) ? div_q : count_q - 1'b1;
      // a reload event beats a clear in the same cycle
      if (wrap)
        pend_q <= 1'b1;
      else if (cfg_we && cfg_ack)
        pend_q <= 1'b0;
    end
  end

  assign count   = count_q;
  assign pending = pend_q;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import timer_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DIV_W      = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tick_slow,
  input  logic                              tick_fast,
  input  logic                              ctrl_we,
  input  logic [NUM_TIMERS*(DIV_W+4)-1:0]   ctrl_wdata,
  input  logic                              mask_we,
  input  logic [NUM_TIMERS-1:0]             mask_wdata,
  output logic [NUM_TIMERS*DIV_W-1:0]       count_pair,
  output logic [NUM_TIMERS-1:0]             pend,
  output logic                              irq
);
  localparam int FIELD_W = DIV_W + CTL_EXTRA;
  localparam int SEL_LO  = DIV_W;
  localparam int RUN_BIT = DIV_W + 2;
  localparam int ACK_BIT = DIV_W + 3;

  logic [NUM_TIMERS-1:0] wrap_v;
  logic [NUM_TIMERS-1:0] tick_v;
  logic [NUM_TIMERS-1:0] chain_v;
  logic [NUM_TIMERS-1:0] mask_q;

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    logic [FIELD_W-1:0] slice;
    assign slice = ctrl_wdata[g*FIELD_W +: FIELD_W];

    if (g == 0) begin : g_head
      assign chain_v[g] = 1'b0;
    end else begin : g_link
      assign chain_v[g] = wrap_v[g-1];
    end

    tick_mux #(.HAS_CHAIN(g != 0)) i_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (ctrl_we),
      .sel_in    (slice[SEL_LO +: 2]),
      .tick_slow (tick_slow),
      .tick_fast (tick_fast),
      .chain_in  (chain_v[g]),
      .tick      (tick_v[g])
    );

    down_counter #(.DIV_W(DIV_W)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (ctrl_we),
      .cfg_div (slice[DIV_W-1:0]),
      .cfg_run (slice[RUN_BIT]),
      .cfg_ack (slice[ACK_BIT]),
      .tick    (tick_v[g]),
      .count   (count_pair[g*DIV_W +: DIV_W]),
      .wrap    (wrap_v[g]),
      .pending (pend[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign irq = |(pend & mask_q);
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int NUM_TIMERS = 2,
  parameter int DIV_W      = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            tick_slow,
  input logic                            tick_fast,
  input logic                            ctrl_we,
  input logic [NUM_TIMERS*(DIV_W+4)-1:0] ctrl_wdata,
  input logic [NUM_TIMERS-1:0]           wrap_v,
  input logic [NUM_TIMERS*DIV_W-1:0]     count_pair,
  input logic [NUM_TIMERS-1:0]           pend,
  input logic                            irq
);
  localparam int ACK0 = DIV_W + 3;

  // R3: with no tick and no write, no count moves
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_slow && !tick_fast && !ctrl_we) |=> $stable(count_pair));

  // R4: a reload event leaves the pending flag set
  p_wrap_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_v[0] |=> pend[0]);

  // R8: a clear with no coinciding reload event empties the flag
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[ACK0] && !wrap_v[0]) |=> !pend[0]);

  // R9: without a clear the flag stays set
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && !(ctrl_we && ctrl_wdata[ACK0])) |=> pend[0]);

  // R10: no pending flag means no interrupt
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq);
endmodule

bind dual_tick_timer timer_checker #(.NUM_TIMERS(NUM_TIMERS), .DIV_W(DIV_W)) i_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_slow  (tick_slow),
  .tick_fast  (tick_fast),
  .ctrl_we    (ctrl_we),
  .ctrl_wdata (ctrl_wdata),
  .wrap_v     (wrap_v),
  .count_pair (count_pair),
  .pend       (pend),
  .irq        (irq)
);

// File: tb/test_dual_tick_timer.sv
module test_dual_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [23:0] ctrl_wdata = '0;
  logic        mask_we = 1'b0;
  logic [1:0]  mask_wdata = '0;
  logic [15:0] count_pair;
  logic [1:0]  pend;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dual_tick_timer i_dual_tick_timer (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .count_pair(count_pair), .pend(pend), .irq(irq)
  );

  // slice layout per R2: {clear, run, source[1:0], reload[7:0]}
  function automatic logic [11:0] fld(input logic [7:0] d, input logic [1:0] s,
                                      input logic run, input logic ack);
    return {ack, run, s, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] w);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = w;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_tick(input logic [23:0] w);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = w; tick_slow = 1'b1;
    @(negedge clk); ctrl_we = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic wr_mask(input logic [1:0] m);
    @(negedge clk); mask_we = 1'b1; mask_wdata = m;
    @(negedge clk); mask_we = 1'b0;
  endtask

  task automatic pulse(input logic s, input logic f, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_slow = s; tick_fast = f;
      @(negedge clk); tick_slow = 1'b0; tick_fast = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R1 counts", count_pair, 16'h0000);
    chk("R1 pend", pend, 2'b00);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_hold;
    wr({fld(0, 3, 0, 1), fld(5, 0, 0, 0)});
    chk("R2 R3 hold load", count_pair, 16'h0005);
    pulse(1, 1, 3);
    chk("R3 hold ignores ticks", count_pair, 16'h0005);
  endtask

  task automatic t_run;
    wr({fld(0, 3, 0, 1), fld(5, 0, 1, 0)});
    chk("R4 start loads", count_pair[7:0], 8'd5);
    pulse(0, 1, 2);
    chk("R6 fast ignored on slow", count_pair[7:0], 8'd5);
    pulse(1, 0, 4);
    chk("R4 count at 1", count_pair[7:0], 8'd1);
    chk("R4 no flag yet", pend[0], 1'b0);
    pulse(1, 0, 1);
    chk("R4 reload", count_pair[7:0], 8'd5);
    chk("R4 flag set", pend[0], 1'b1);
  endtask

  task automatic t_ack;
    wr({fld(0, 3, 0, 0), fld(5, 0, 1, 0)});
    chk("R8 no-op keeps flag", pend[0], 1'b1);
    pulse(1, 0, 2);
    chk("R9 sticky", pend[0], 1'b1);
    chk("R4 running through write", count_pair[7:0], 8'd3);
    wr({fld(0, 3, 0, 0), fld(5, 0, 1, 1)});
    chk("R8 clear", pend[0], 1'b0);
    pulse(1, 0, 2);
    wr_tick({fld(0, 3, 0, 0), fld(5, 0, 1, 1)});
    chk("R8 reload beats clear", pend[0], 1'b1);
    chk("R8 reload value", count_pair[7:0], 8'd5);
  endtask

  task automatic t_mask;
    chk("R10 masked off", irq, 1'b0);
    wr_mask(2'b01);
    chk("R10 unmasked", irq, 1'b1);
    wr_mask(2'b10);
    chk("R10 other bit", irq, 1'b0);
    wr_mask(2'b00);
  endtask

  task automatic t_hundred_hz;
    wr({fld(0, 3, 0, 1), fld(192, 0, 0, 1)});
    wr({fld(0, 3, 0, 0), fld(192, 0, 1, 0)});
    pulse(1, 0, 191);
    chk("R4 192 at 1", count_pair[7:0], 8'd1);
    chk("R4 192 no flag", pend[0], 1'b0);
    pulse(1, 0, 1);
    chk("R4 192 reload", count_pair[7:0], 8'd192);
    chk("R4 192 flag", pend[0], 1'b1);
  endtask

  task automatic t_zero;
    wr({fld(0, 3, 0, 1), fld(0, 0, 0, 1)});
    wr({fld(0, 3, 0, 0), fld(0, 0, 1, 0)});
    chk("R5 start zero", count_pair[7:0], 8'd0);
    pulse(1, 0, 1);
    chk("R5 next 255", count_pair[7:0], 8'd255);
    pulse(1, 0, 254);
    chk("R5 at 1", count_pair[7:0], 8'd1);
    chk("R5 no flag", pend[0], 1'b0);
    pulse(1, 0, 1);
    chk("R5 wrap to 0", count_pair[7:0], 8'd0);
    chk("R5 flag", pend[0], 1'b1);
  endtask

  task automatic t_fast_off;
    wr({fld(3, 1, 0, 1), fld(0, 3, 0, 1)});
    wr({fld(3, 1, 1, 0), fld(0, 3, 0, 0)});
    chk("R6 t1 loaded", count_pair, 16'h0300);
    pulse(1, 0, 2);
    chk("R6 slow ignored on fast", count_pair, 16'h0300);
    pulse(0, 1, 3);
    chk("R6 fast wraps t1", pend[1], 1'b1);
    chk("R6 t1 reload", count_pair[15:8], 8'd3);
    wr({fld(3, 3, 1, 1), fld(0, 3, 0, 0)});
    pulse(1, 1, 2);
    chk("R6 source off holds", count_pair[15:8], 8'd3);
    chk("R8 t1 clear", pend[1], 1'b0);
  endtask

  task automatic t_t0_chain;
    wr({fld(0, 3, 0, 1), fld(4, 2, 0, 1)});
    wr({fld(0, 3, 0, 0), fld(4, 2, 1, 0)});
    pulse(1, 1, 2);
    chk("R6 t0 code 2 no tick", count_pair[7:0], 8'd4);
  endtask

  task automatic t_cascade;
    wr({fld(3, 2, 0, 1), fld(2, 0, 0, 1)});
    wr({fld(3, 2, 1, 0), fld(2, 0, 1, 0)});
    chk("R11 pair start", count_pair, 16'h0302);
    pulse(1, 0, 2);
    chk("R7 one reload", count_pair, 16'h0202);
    pulse(1, 0, 2);
    chk("R7 R11 two reloads", count_pair, 16'h0102);
    chk("R7 t1 no flag", pend[1], 1'b0);
    pulse(1, 0, 2);
    chk("R7 t1 wraps", count_pair, 16'h0302);
    chk("R7 t1 flag", pend[1], 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_run();
    t_ack();
    t_mask();
    t_hundred_hz();
    t_zero();
    t_fast_off();
    t_t0_chain();
    t_cascade();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule